// File: doc/BRIEF.md
# Timer Channel Clock Gate and Trigger Control

This block decides, for one timer/counter channel, whether the counter advances on a given tick of its selected clock. It holds two independent state bits. The enable latch is owned by software: an enable command sets it, and a disable command clears it. A mode-dependent hardware event may also clear it. The run latch is set by any trigger and cleared by a mode-dependent stop event. The counter advances only while both latches are set.

The selected clock arrives as a one-cycle `tickEn` pulse in the system clock domain. A trigger does not zero the counter at once. It arms a pending clear, and that clear is applied on the next `tickEn`. The counter can therefore still show its old value for some cycles after a trigger. A mode input selects capture behaviour or waveform behaviour. In capture mode the register-B load pulse is the qualifying event. In waveform mode the register-C compare pulse is the qualifying event, and that pulse can also act as a trigger.

Top module: `timer_gate_ctl`

## Requirements
- R1: After reset, `enabled`, `running` and `gatedTick` are 0 and `count` is 0.
- R2: `cmdEnable` sets `enabled` on the next clock edge and `cmdDisable` clears it. When both are asserted in the same cycle, `enabled` ends at 0.
- R3: In capture mode (`waveMode`=0), a `loadBEvt` pulse with `optLdbDisable`=1 clears `enabled`. In waveform mode, `loadBEvt` has no effect on either latch.
- R4: In waveform mode (`waveMode`=1), a `cmpCEvt` pulse with `optCpcDisable`=1 clears `enabled`. In capture mode, `cmpCEvt` has no effect on `enabled`.
- R5: While `enabled` is 0, triggers and stop events leave `running` and `count` unchanged, and `gatedTick` stays 0.
- R6: While `enabled` is 1, any of `swTrig`, `syncTrig` or `extTrig` sets `running` on the next edge. In waveform mode, `cmpCEvt` with `optCpcTrig`=1 does the same.
- R7: While `enabled` is 1, `running` is cleared in capture mode by `loadBEvt` with `optLdbStop`=1, and in waveform mode by `cmpCEvt` with `optCpcStop`=1.
- R8: When an accepted trigger and a stop event occur in the same cycle, `running` ends at 1.
- R9: An accepted trigger zeroes `count` on the next `tickEn` (the same cycle, if it coincides with one). `count` keeps its old value until that tick.
- R10: `gatedTick` equals `tickEn` while both latches are set. Each such tick, when no clear is pending, raises `count` by one. Without `tickEn`, `count` does not change.
- R11: When `cmdEnable` coincides with a hardware disable event, `enabled` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Selected-clock tick, one cycle wide |
| waveMode | input | 1 | 0 = capture mode, 1 = waveform mode |
| cmdEnable | input | 1 | Software enable command |
| cmdDisable | input | 1 | Software disable command |
| swTrig | input | 1 | Software trigger |
| syncTrig | input | 1 | Synchronization trigger |
| extTrig | input | 1 | External trigger |
| loadBEvt | input | 1 | Register-B load pulse |
| cmpCEvt | input | 1 | Register-C compare pulse |
| optLdbDisable | input | 1 | Capture: load-B clears enable |
| optLdbStop | input | 1 | Capture: load-B clears run |
| optCpcDisable | input | 1 | Waveform: compare-C clears enable |
| optCpcStop | input | 1 | Waveform: compare-C clears run |
| optCpcTrig | input | 1 | Waveform: compare-C acts as trigger |
| enabled | output | 1 | Status: enable latch |
| running | output | 1 | Run latch |
| gatedTick | output | 1 | Qualified counter tick |
| count | output | CNT_W | Counter value |

## Verification
Both latches are registers, so `enabled` and `running` reflect a command or event exactly one system clock edge after the cycle in which it is presented. The bench drives each input set on a falling edge and samples both latches at the following falling edge. `gatedTick` is combinational from `tickEn` and the latch states, so it is sampled in the same cycle as the tick it qualifies, before the edge. `count` moves only on the edge that ends a `tickEn` cycle. Deferred-clear checks therefore sample `count` once after the trigger cycle with no tick, and again after the first tick.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  // Strobes from control to the counter datapath
  typedef struct packed {
    logic incr;   // advance counter by one
    logic clr;    // zero the counter
  } strobe_t;
endpackage

// File: rtl/tgc_ctrl.sv
module tgc_ctrl
  import tgc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tickEn,
  input  logic    waveMode,
  input  logic    cmdEnable,
  input  logic    cmdDisable,
  input  logic    swTrig,
  input  logic    syncTrig,
  input  logic    extTrig,
  input  logic    loadBEvt,
  input  logic    cmpCEvt,
  input  logic    optLdbDisable,
  input  logic    optLdbStop,
  input  logic    optCpcDisable,
  input  logic    optCpcStop,
  input  logic    optCpcTrig,
  output logic    enLatch,
  output logic    runLatch,
  output logic    qualTick,
  output strobe_t strb
);
  logic hwDisable, stopEvt, anyTrig, trigTaken, clrPending;

  // Mode-dependent qualifying events
  always_comb begin
    if (waveMode) begin
      hwDisable = cmpCEvt & optCpcDisable;
      stopEvt   = cmpCEvt & optCpcStop;
      anyTrig   = swTrig | syncTrig | extTrig | (cmpCEvt & optCpcTrig);
    end else begin
      hwDisable = loadBEvt & optLdbDisable;
      stopEvt   = loadBEvt & optLdbStop;
      anyTrig   = swTrig | syncTrig | extTrig;
    end
  end

  assign trigTaken = anyTrig & enLatch;

  // Enable latch: sw disable > sw enable > hardware disable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           enLatch <= 1'b0;
    else if (cmdDisable) enLatch <= 1'b0;
    else if (cmdEnable)  enLatch <= 1'b1;
    else if (hwDisable)  enLatch <= 1'b0;
  end

  // Run latch: only moves while enabled; trigger beats stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      runLatch <= 1'b0;
    else if (trigTaken)             runLatch <= 1'b1;
    else if (enLatch && stopEvt)    runLatch <= 1'b0;
  end

  // Deferred counter clear, consumed by the next tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      clrPending <= 1'b0;
    else if (tickEn)                clrPending <= 1'b0;
    else if (trigTaken)             clrPending <= 1'b1;
  end

  assign qualTick = tickEn & enLatch & runLatch;

  always_comb begin
    strb.clr  = tickEn & (clrPending | trigTaken);
    strb.incr = qualTick & ~strb.clr;
  end
endmodule

// File: rtl/tgc_count.sv
module tgc_count
  import tgc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (strb.clr)  cnt <= '0;
    else if (strb.incr) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/timer_gate_ctl.sv
module timer_gate_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             waveMode,
  input  logic             cmdEnable,
  input  logic             cmdDisable,
  input  logic             swTrig,
  input  logic             syncTrig,
  input  logic             extTrig,
  input  logic             loadBEvt,
  input  logic             cmpCEvt,
  input  logic             optLdbDisable,
  input  logic             optLdbStop,
  input  logic             optCpcDisable,
  input  logic             optCpcStop,
  input  logic             optCpcTrig,
  output logic             enabled,
  output logic             running,
  output logic             gatedTick,
  output logic [CNT_W-1:0] count
);
  tgc_pkg::strobe_t strb;

  tgc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .waveMode(waveMode),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable),
    .swTrig(swTrig), .syncTrig(syncTrig), .extTrig(extTrig),
    .loadBEvt(loadBEvt), .cmpCEvt(cmpCEvt),
    .optLdbDisable(optLdbDisable), .optLdbStop(optLdbStop),
    .optCpcDisable(optCpcDisable), .optCpcStop(optCpcStop),
    .optCpcTrig(optCpcTrig),
    .enLatch(enabled), .runLatch(running), .qualTick(gatedTick),
    .strb(strb)
  );

  tgc_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(count)
  );
endmodule

// File: rtl/timer_gate_ctl_checker.sv
module timer_gate_ctl_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             cmdEnable,
  input logic             cmdDisable,
  input logic             swTrig,
  input logic             enabled,
  input logic             running,
  input logic             gatedTick,
  input logic [CNT_W-1:0] count
);
  // R2
  a_r2_disable_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmdDisable |=> !enabled);
  // R2
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmdEnable && !cmdDisable) |=> enabled);
  // R5
  a_r5_run_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> $stable(running));
  // R5
  a_r5_no_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !gatedTick);
  // R8
  a_r8_trig_wins: assert property (@(posedge clk) disable iff (!rstN)
    (enabled && swTrig) |=> running);
  // R10
  a_r10_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count));
endmodule

bind timer_gate_ctl timer_gate_ctl_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmdEnable(cmdEnable),
  .cmdDisable(cmdDisable), .swTrig(swTrig), .enabled(enabled),
  .running(running), .gatedTick(gatedTick), .count(count)
);

// File: tb/timer_gate_ctl_tb_top.sv
module timer_gate_ctl_tb_top;
  localparam int CNT_W = 16;
  localparam int NVEC  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, waveMode = 0, cmdEnable = 0, cmdDisable = 0;
  logic swTrig = 0, syncTrig = 0, extTrig = 0, loadBEvt = 0, cmpCEvt = 0;
  logic optLdbDisable = 0, optLdbStop = 0, optCpcDisable = 0, optCpcStop = 0, optCpcTrig = 0;
  logic enabled, running, gatedTick;
  logic [CNT_W-1:0] count;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #4 clk = ~clk;  // 125 MHz

  timer_gate_ctl #(.CNT_W(CNT_W)) dut_i (.*);

  // Vector fields: [13]wave [12]en [11]dis [10]sw [9]sync [8]ext [7]ldB [6]cmpC
  //                [5]ldbDis [4]ldbStop [3]cpcDis [2]cpcStop [1]expEn [0]expRun
  localparam logic [13:0] VEC [NVEC] = '{
    14'b0_1_0_000_00_0000_10,  // R2 enable
    14'b0_0_0_100_00_0000_11,  // R6 sw trigger
    14'b0_0_0_000_10_0100_10,  // R7 capture stop via load B
    14'b0_0_0_010_00_0000_11,  // R6 sync trigger
    14'b0_0_0_000_10_1000_01,  // R3 capture disable via load B
    14'b0_0_0_000_10_0100_01,  // R5 stop ignored while disabled
    14'b0_1_1_000_00_0000_01,  // R2 disable beats enable
    14'b0_1_0_000_00_0000_11,  // R2 re-enable
    14'b1_0_0_000_10_1100_11,  // R3 load B ignored in waveform
    14'b1_0_0_000_01_0001_10,  // R7 waveform stop via compare C
    14'b1_0_0_001_01_0001_11,  // R8 trigger beats stop
    14'b0_0_0_000_01_0010_11,  // R4 compare C ignored in capture
    14'b1_0_0_000_01_0010_01,  // R4 waveform disable via compare C
    14'b1_1_0_000_01_0010_11,  // R11 enable beats hw disable
    14'b0_0_0_000_01_0011_11,  // R4/R7 compare C ignored in capture
    14'b0_0_1_000_00_0000_01   // R2 disable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    tickEn = 0; waveMode = 0; cmdEnable = 0; cmdDisable = 0;
    swTrig = 0; syncTrig = 0; extTrig = 0; loadBEvt = 0; cmpCEvt = 0;
    optLdbDisable = 0; optLdbStop = 0; optCpcDisable = 0; optCpcStop = 0; optCpcTrig = 0;
  endtask

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
    clearIn();
  endtask

  task automatic doReset();
    rstN = 0;
    clearIn();
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    doReset();
    check("R1 enabled", enabled, 0);
    check("R1 running", running, 0);
    check("R1 count", count, 0);
    check("R1 gatedTick", gatedTick, 0);

    for (int i = 0; i < NVEC; i++) begin
      {waveMode, cmdEnable, cmdDisable, swTrig, syncTrig, extTrig, loadBEvt, cmpCEvt,
       optLdbDisable, optLdbStop, optCpcDisable, optCpcStop} = VEC[i][13:2];
      nextCycle();
      check($sformatf("vec%0d enabled", i), enabled, VEC[i][1]);
      check($sformatf("vec%0d running", i), running, VEC[i][0]);
    end

    // Counter behaviour
    doReset();
    cmdEnable = 1; nextCycle();
    swTrig = 1; nextCycle();
    for (int k = 0; k < 5; k++) begin
      tickEn = 1;
      #1 check("R10 gatedTick high", gatedTick, 1);
      nextCycle();
    end
    check("R9/R10 count after clear+4 incr", count, 4);
    check("R10 count idle", count, 4);
    swTrig = 1; nextCycle();
    check("R9 count held until tick", count, 4);
    nextCycle();
    check("R9 count still held", count, 4);
    tickEn = 1; nextCycle();
    check("R9 count cleared on tick", count, 0);
    tickEn = 1; nextCycle();
    check("R10 count incr", count, 1);
    tickEn = 1; swTrig = 1; nextCycle();
    check("R9 trigger coincident with tick", count, 0);
    cmdDisable = 1; nextCycle();
    tickEn = 1;
    #1 check("R5 gatedTick low when disabled", gatedTick, 0);
    nextCycle();
    check("R5 count frozen when disabled", count, 0);
    swTrig = 1; tickEn = 1; nextCycle();
    check("R5 trigger ignored count", count, 0);

    // Compare C as trigger in waveform mode
    cmdEnable = 1; nextCycle();
    waveMode = 1; cmpCEvt = 1; optCpcStop = 1; nextCycle();
    check("R7 waveform stop", running, 0);
    tickEn = 1;
    #1 check("R10 gatedTick low when stopped", gatedTick, 0);
    nextCycle();
    waveMode = 1; cmpCEvt = 1; optCpcTrig = 1; nextCycle();
    check("R6 compare C trigger", running, 1);
    waveMode = 0; cmpCEvt = 1; optCpcStop = 1; nextCycle();
    check("R4 compare C stop ignored in capture", running, 1);
    waveMode = 0; cmdDisable = 1; nextCycle();
    waveMode = 0; loadBEvt = 1; optLdbStop = 1; nextCycle();
    check("R5 stop ignored while disabled", running, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule